// File: doc/BRIEF.md
# Isochronous Endpoint Error Flags

This block watches one isochronous device endpoint and reports two kinds of fault: a buffer fault (the host side and the CPU side of the endpoint buffer out of step) and a packet fault (a damaged incoming packet). A single direction input selects the endpoint's role.

In the receive role, each received packet is checked against a buffer-ready bit and against the CRC and bit-stuffing results. A packet that arrives while the CPU still holds the buffer, or that arrived damaged, is thrown away. In the transmit role, each IN token is checked against the same ready bit. A token that arrives before the CPU has finished filling the buffer is answered with a zero-length packet.

Every fault raises a one-cycle not-ready interrupt and sets one or both sticky flags. The overrun flag reads as receive overrun or transmit underrun, depending on the direction. The CRC flag marks damaged received packets. Software clears each flag with its own strobe. All outputs are registered, and each responds one clock after the strobe that caused it.

Top module: `iso_err_flags`

## Requirements
- R1: In receive role (`dir_tx_i`=0), a `pkt_rx_i` strobe while the buffer-ready bit is 0 sets `ovr_o` and pulses `nrdy_o` on the following clock.
- R2: A receive overrun pulses `discard_o` and not `pkt_accept_o`, and it leaves the buffer-ready bit unchanged.
- R3: In receive role, `pkt_rx_i` with `crc_err_i` or `stuff_err_i` high sets `crc_o` and pulses `nrdy_o` on the following clock.
- R4: A received packet with a CRC or stuffing error pulses `discard_o`, does not pulse `pkt_accept_o`, and leaves the buffer-ready bit unchanged.
- R5: In transmit role (`dir_tx_i`=1), an `in_tok_i` strobe while the buffer-ready bit is 0 sets `ovr_o` and pulses `nrdy_o` on the following clock.
- R6: A transmit underrun pulses `zlp_req_o`. An IN token that arrives while the buffer is ready pulses `tx_send_o` instead.
- R7: `crc_o` never becomes set in transmit role. There, `crc_err_i`, `stuff_err_i` and `pkt_rx_i` have no effect on any output.
- R8: `ovr_o` and `crc_o` are sticky. Each clears only on its clear strobe (`clr_ovr_i`, `clr_crc_i`). A new error in the same cycle as the clear strobe keeps the flag set.
- R9: The buffer-ready bit is set by `rd_done_i` in receive role or by `wr_done_i` in transmit role; the other handshake is ignored. A successful transfer (`pkt_accept_o` or `tx_send_o`) clears the bit. After reset the bit holds parameter `RDY_RST`.
- R10: If one received packet shows both an overrun and a CRC or stuffing error, both flags are set and `nrdy_o` pulses for exactly one cycle.
- R11: During and after reset, every output is 0 until the first event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_tx_i | input | 1 | Endpoint role: 0 receive, 1 transmit |
| pkt_rx_i | input | 1 | Strobe: a data packet has been received |
| crc_err_i | input | 1 | CRC failure of the packet, valid with `pkt_rx_i` |
| stuff_err_i | input | 1 | Bit-stuffing failure of the packet, valid with `pkt_rx_i` |
| in_tok_i | input | 1 | Strobe: an IN token has been received |
| rd_done_i | input | 1 | CPU has finished reading the buffer |
| wr_done_i | input | 1 | CPU has finished writing the buffer |
| clr_ovr_i | input | 1 | Software clear of the overrun flag |
| clr_crc_i | input | 1 | Software clear of the CRC flag |
| pkt_accept_o | output | 1 | Pulse: received packet is kept in the buffer |
| discard_o | output | 1 | Pulse: received packet is thrown away |
| tx_send_o | output | 1 | Pulse: send the buffer contents for this token |
| zlp_req_o | output | 1 | Pulse: answer this token with a zero-length packet |
| nrdy_o | output | 1 | Not-ready interrupt pulse |
| ovr_o | output | 1 | Sticky overrun/underrun flag |
| crc_o | output | 1 | Sticky received-packet error flag |

## Verification
The bench builds the block with `RDY_RST` = 1. In that configuration the first packet after reset is accepted, and the directed sequence then moves on through overrun, a damaged packet, a combined fault and a transmit underrun. A long random run follows. It mixes strobes, handshakes, clear strobes and direction changes, so that clears meet new errors in the same cycle and handshakes arrive together with transfers. A behavioural model checks every output on every clock.

// File: rtl/iso_err_pkg.sv
package iso_err_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

  typedef struct packed {
    logic accept;
    logic discard;
    logic send;
    logic zlp;
    logic ovr;
    logic crc;
  } verdict_t;
endpackage

// File: rtl/iso_buf_track.sv
module iso_buf_track #(
  parameter logic RDY_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_tx_i,
  input  logic rd_done_i,
  input  logic wr_done_i,
  input  logic consume_i,
  output logic rdy_o
);
  import iso_err_pkg::*;

  logic done;
  assign done = (dir_e'(dir_tx_i) == DIR_TX) ? wr_done_i : rd_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_o <= RDY_RST;
    else         rdy_o <= (rdy_o & ~consume_i) | done;
  end

  a_r9_rdy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !consume_i) |=> rdy_o);
endmodule

// File: rtl/iso_err_judge.sv
module iso_err_judge (
  input  logic                  dir_tx_i,
  input  logic                  pkt_rx_i,
  input  logic                  crc_err_i,
  input  logic                  stuff_err_i,
  input  logic                  in_tok_i,
  input  logic                  rdy_i,
  output iso_err_pkg::verdict_t v_o
);
  import iso_err_pkg::*;

  logic rx_evt, tx_evt, bad, ovr_rx;

  always_comb begin
    rx_evt = pkt_rx_i & (dir_e'(dir_tx_i) == DIR_RX);
    tx_evt = in_tok_i & (dir_e'(dir_tx_i) == DIR_TX);
    bad    = rx_evt & (crc_err_i | stuff_err_i);
    ovr_rx = rx_evt & ~rdy_i;
    v_o.crc     = bad;
    v_o.ovr     = ovr_rx | (tx_evt & ~rdy_i);
    v_o.discard = bad | ovr_rx;
    v_o.accept  = rx_evt & ~bad & ~ovr_rx;
    v_o.zlp     = tx_evt & ~rdy_i;
    v_o.send    = tx_evt & rdy_i;
  end

  a_r2_accept_excl: assert final (!(v_o.accept && v_o.discard));
  a_r6_send_excl:   assert final (!(v_o.send && v_o.zlp));
endmodule

// File: rtl/iso_err_status.sv
module iso_err_status (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  iso_err_pkg::verdict_t v_i,
  input  logic                  clr_ovr_i,
  input  logic                  clr_crc_i,
  output logic                  accept_o,
  output logic                  discard_o,
  output logic                  send_o,
  output logic                  zlp_o,
  output logic                  nrdy_o,
  output logic                  ovr_o,
  output logic                  crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      discard_o <= 1'b0;
      send_o    <= 1'b0;
      zlp_o     <= 1'b0;
      nrdy_o    <= 1'b0;
      ovr_o     <= 1'b0;
      crc_o     <= 1'b0;
    end else begin
      accept_o  <= v_i.accept;
      discard_o <= v_i.discard;
      send_o    <= v_i.send;
      zlp_o     <= v_i.zlp;
      nrdy_o    <= v_i.ovr | v_i.crc;
      // a new error wins over a clear in the same cycle
      ovr_o     <= (ovr_o & ~clr_ovr_i) | v_i.ovr;
      crc_o     <= (crc_o & ~clr_crc_i) | v_i.crc;
    end
  end

  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_ovr_i) |=> ovr_o);
  a_r8_crc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_o && !clr_crc_i) |=> crc_o);
endmodule

// File: rtl/iso_err_flags.sv
module iso_err_flags #(
  parameter logic RDY_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_tx_i,
  input  logic pkt_rx_i,
  input  logic crc_err_i,
  input  logic stuff_err_i,
  input  logic in_tok_i,
  input  logic rd_done_i,
  input  logic wr_done_i,
  input  logic clr_ovr_i,
  input  logic clr_crc_i,
  output logic pkt_accept_o,
  output logic discard_o,
  output logic tx_send_o,
  output logic zlp_req_o,
  output logic nrdy_o,
  output logic ovr_o,
  output logic crc_o
);
  import iso_err_pkg::*;

  logic     rdy;
  verdict_t v;

  iso_buf_track #(.RDY_RST(RDY_RST)) u_track (
    .clk_i, .rst_ni, .dir_tx_i, .rd_done_i, .wr_done_i,
    .consume_i(v.accept | v.send),
    .rdy_o(rdy)
  );

  iso_err_judge u_judge (
    .dir_tx_i, .pkt_rx_i, .crc_err_i, .stuff_err_i, .in_tok_i,
    .rdy_i(rdy),
    .v_o(v)
  );

  iso_err_status u_status (
    .clk_i, .rst_ni, .v_i(v), .clr_ovr_i, .clr_crc_i,
    .accept_o(pkt_accept_o), .discard_o, .send_o(tx_send_o),
    .zlp_o(zlp_req_o), .nrdy_o, .ovr_o, .crc_o
  );

  a_r1_rx_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_rx_i && !dir_tx_i && !rdy) |=> (ovr_o && nrdy_o && discard_o));
  a_r5_tx_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tok_i && dir_tx_i && !rdy) |=> (ovr_o && nrdy_o && zlp_req_o));
  a_r7_no_crc_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_tx_i && !crc_o) |=> !crc_o);
  a_r4_bad_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_rx_i && !dir_tx_i && (crc_err_i || stuff_err_i)) |=> (discard_o && !pkt_accept_o));
endmodule

// File: tb/tb_iso_err_flags.sv
module tb_iso_err_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_tx = 0, pkt = 0, crc_e = 0, stf_e = 0, tok = 0;
  logic rd_done = 0, wr_done = 0, clr_o = 0, clr_c = 0;
  logic acc, disc, send, zlp, nrdy, ovr, crc;

  int checks = 0, errors = 0;
  string phase = "R11 reset";

  always #10 clk = ~clk;

  iso_err_flags #(.RDY_RST(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_tx_i(dir_tx), .pkt_rx_i(pkt),
    .crc_err_i(crc_e), .stuff_err_i(stf_e), .in_tok_i(tok),
    .rd_done_i(rd_done), .wr_done_i(wr_done),
    .clr_ovr_i(clr_o), .clr_crc_i(clr_c),
    .pkt_accept_o(acc), .discard_o(disc), .tx_send_o(send),
    .zlp_req_o(zlp), .nrdy_o(nrdy), .ovr_o(ovr), .crc_o(crc)
  );

  // behavioural reference
  bit m_rdy, m_acc, m_disc, m_send, m_zlp, m_nrdy, m_ovr, m_crc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 1; {m_acc, m_disc, m_send, m_zlp, m_nrdy, m_ovr, m_crc} = '0;
    end else begin
      bit got_overrun, got_bad, rx_mode;
      rx_mode = !dir_tx;
      got_overrun = 0; got_bad = 0;
      m_acc = 0; m_disc = 0; m_send = 0; m_zlp = 0;
      if (clr_o) m_ovr = 0;
      if (clr_c) m_crc = 0;
      if (rx_mode && pkt) begin
        if (crc_e || stf_e) got_bad = 1;
        if (!m_rdy) got_overrun = 1;
        if (got_bad || got_overrun) m_disc = 1;
        else begin m_acc = 1; m_rdy = 0; end
      end
      if (!rx_mode && tok) begin
        if (m_rdy) begin m_send = 1; m_rdy = 0; end
        else begin m_zlp = 1; got_overrun = 1; end
      end
      if (got_overrun) m_ovr = 1;
      if (got_bad) m_crc = 1;
      m_nrdy = got_overrun || got_bad;
      if (rx_mode ? rd_done : wr_done) m_rdy = 1;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%b expected=%b at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R9 pkt_accept", acc, m_acc);
    chk("R2 R4 discard", disc, m_disc);
    chk("R6 tx_send", send, m_send);
    chk("R6 zlp_req", zlp, m_zlp);
    chk("R10 nrdy", nrdy, m_nrdy);
    chk("R1 R5 R8 ovr", ovr, m_ovr);
    chk("R3 R7 R8 crc", crc, m_crc);
  endtask

  task automatic cyc(string ph, logic d, logic p, logic ce, logic se, logic t,
                     logic rd, logic wr, logic co, logic cc);
    phase = ph;
    dir_tx = d; pkt = p; crc_e = ce; stf_e = se; tok = t;
    rd_done = rd; wr_done = wr; clr_o = co; clr_c = cc;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R11 reset";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    //       phase              d  p  ce se t  rd wr co cc
    cyc("R9 first accept",      0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 R2 overrun",        0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 clear ovr",         0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R9 read done",         0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R3 R4 crc bad",        0, 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R4 rdy kept accept",   0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10 double fault",     0, 1, 0, 1, 0, 0, 0, 0, 0);
    cyc("R10 single pulse",     0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 clear both",        0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R7 tx ignores rx",     1, 1, 1, 1, 0, 1, 0, 0, 0);
    cyc("R5 R6 underrun",       1, 0, 1, 0, 1, 0, 0, 0, 0);
    cyc("R9 write done",        1, 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R6 send",              1, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R8 set wins clear",    1, 0, 0, 0, 1, 0, 0, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      logic d;
      d = (i / 200) % 2;
      cyc("random R1 R3 R5 R8 R9", d, ($urandom % 3) == 0, ($urandom % 5) == 0,
          ($urandom % 7) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
          ($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0);
    end
    finish_run();
  end
endmodule